// File: doc/BRIEF.md
# Synchronous Shift Serial Port

This block is a half-duplex serial port that moves one byte at a time over a single data line. It drives its own shift clock, and all of its timing is counted in cycles of one system clock. Writing a byte to the port while it is idle starts a transmit. Raising the receive enable while the receive-complete flag is clear starts a receive. Each transfer moves eight bits, least significant bit first. When a transfer ends, the matching completion flag is set and stays set until the host clears it.

A speed bit picks the bit period: 12 system clocks (slow) or 4 system clocks (fast). The port captures this bit when a transfer starts, so changing it during a transfer has no effect. Within each bit, the shift clock goes low at the start of the bit and stays low for a fixed number of cycles: 10 in slow mode, 3 in fast mode. It then goes high for the rest of the bit: 2 cycles or 1 cycle. Transmit data changes only at the start of a bit. Receive data is captured at the rising edge of the shift clock. The bidirectional line is split into three signals: an input, an output and an output enable.

Top module: `ssp_sync_port`

## Requirements
- R1: Every bit lasts 12 system clocks when `fastMode` was 0 at the start edge, and 4 when it was 1. A whole transfer keeps `busy` high for exactly 96 or 32 cycles. Changing `fastMode` during a transfer has no effect.
- R2: `shiftClk` is 1 whenever the port is idle. During a transfer, let k be the number of cycles since the start of the current bit. `shiftClk` is 0 for k below 10 (slow) or 3 (fast), and 1 for the remaining cycles of the bit.
- R3: During a transmit, `sdOe` is 1 for every cycle of the transfer and 0 at all other times. `sdOut` carries bit b of the written byte for the whole of bit b, with bit 0 first. It changes only at the start of a bit, never in the cycle where `shiftClk` rises.
- R4: During a receive, bit b is taken from `sdIn` at the clock edge that ends the first cycle of bit b in which `shiftClk` is 1. The value of `sdIn` in every other cycle is ignored.
- R5: After a receive, `rxData` holds the eight captured bits, with the first bit received in bit 0. `rxData` is valid in the first cycle after the transfer.
- R6: `txDone` or `rxDone` rises in the first cycle after the last bit, in the same cycle that `busy` falls. The flag stays at 1 until a cycle with `txDoneClr` or `rxDoneClr` high, after which it reads 0.
- R7: While `busy` is 1, `wrEn` and `rxEnable` are ignored, and the byte being transmitted is not changed. While `rxDone` is 1, `rxEnable` does not start a receive.
- R8: If `wrEn` and `rxEnable` are both high in the same idle cycle, a transmit starts.
- R9: A cycle with `rst` high returns the port to idle, even in the middle of a transfer. After it, `busy`, `sdOe`, `txDone` and `rxDone` are 0 and `shiftClk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the transmit byte |
| wrData | input | 8 | Byte to transmit |
| rxEnable | input | 1 | Receive enable (level) |
| fastMode | input | 1 | 0: 12 clocks per bit, 1: 4 clocks per bit |
| txDoneClr | input | 1 | Clears the transmit-complete flag |
| rxDoneClr | input | 1 | Clears the receive-complete flag |
| sdIn | input | 1 | Data line input |
| sdOut | output | 1 | Data line output value |
| sdOe | output | 1 | Data line output enable |
| shiftClk | output | 1 | Shift clock, idles high |
| rxData | output | 8 | Last received byte |
| txDone | output | 1 | Transmit complete flag |
| rxDone | output | 1 | Receive complete flag |
| busy | output | 1 | Transfer in progress |

## Verification
A start request is taken at the clock edge where it is seen. Bit 0 begins in the next cycle, and the cycles of the transfer are counted from there. The completion flag, the low `busy` and a new `rxData` all appear together, exactly 8×P cycles after the start edge, where P is the bit period. The bench samples one nanosecond after each edge and checks `shiftClk`, `sdOe` and `sdOut` against the cycle index within each bit. During a receive, it drives the true bit on `sdIn` only in the first cycle where `shiftClk` is high and drives the inverted bit in every other cycle, so a capture at any other cycle gives a wrong `rxData`.

// File: rtl/sspPkg.sv
package sspPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } sspState_e;

  // strobes sent from the controller to the datapath
  typedef struct packed {
    logic loadTx;     // capture the write byte
    logic clearRx;    // empty the shift register for a receive
    logic shiftTx;    // move to the next transmit bit
    logic sampleRx;   // take one bit from the data line
    logic commitRx;   // publish the received byte
    logic driveLine;  // enable the line driver
  } sspStrobes_t;

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import sspPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4,
  parameter int SLOW_LOW = 10,
  parameter int FAST_LOW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        rxEnable,
  input  logic        fastMode,
  input  logic        txDoneClr,
  input  logic        rxDoneClr,
  output sspStrobes_t strobes,
  output logic        shiftClk,
  output logic        busy,
  output logic        txDone,
  output logic        rxDone
);

  localparam int PH_W  = $clog2(SLOW_DIV);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0]  SLOW_LAST = PH_W'(SLOW_DIV - 1);
  localparam logic [PH_W-1:0]  FAST_LAST = PH_W'(FAST_DIV - 1);
  localparam logic [PH_W-1:0]  SLOW_RISE = PH_W'(SLOW_LOW);
  localparam logic [PH_W-1:0]  FAST_RISE = PH_W'(FAST_LOW);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

  sspState_e        state;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitCnt;
  logic             modeFast;

  logic [PH_W-1:0]  lastPh;
  logic [PH_W-1:0]  risePh;
  logic             bitEnd;
  logic             finalBit;
  logic             startTx;
  logic             startRx;

  always_comb begin
    lastPh   = modeFast ? FAST_LAST : SLOW_LAST;
    risePh   = modeFast ? FAST_RISE : SLOW_RISE;
    busy     = (state != ST_IDLE);
    bitEnd   = busy && (phase == lastPh);
    finalBit = bitEnd && (bitCnt == LAST_BIT);
    startTx  = (state == ST_IDLE) && wrEn;
    startRx  = (state == ST_IDLE) && !wrEn && rxEnable && !rxDone;
  end

  // sequencing: a phase counter within the bit and a bit counter within the byte
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= '0;
      bitCnt   <= '0;
      modeFast <= 1'b0;
    end else if (startTx || startRx) begin
      state    <= startTx ? ST_TX : ST_RX;
      phase    <= '0;
      bitCnt   <= '0;
      modeFast <= fastMode;
    end else if (busy) begin
      if (bitEnd) begin
        phase  <= '0;
        bitCnt <= bitCnt + 1'b1;
        if (finalBit) state <= ST_IDLE;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // completion flags: setting wins over clearing
  always_ff @(posedge clk) begin
    if (rst) begin
      txDone <= 1'b0;
      rxDone <= 1'b0;
    end else begin
      if (state == ST_TX && finalBit) txDone <= 1'b1;
      else if (txDoneClr)             txDone <= 1'b0;
      if (state == ST_RX && finalBit) rxDone <= 1'b1;
      else if (rxDoneClr)             rxDone <= 1'b0;
    end
  end

  always_comb begin
    shiftClk          = !(busy && (phase < risePh));
    strobes.loadTx    = startTx;
    strobes.clearRx   = startRx;
    strobes.shiftTx   = (state == ST_TX) && bitEnd;
    strobes.sampleRx  = (state == ST_RX) && (phase == risePh);
    strobes.commitRx  = (state == ST_RX) && finalBit;
    strobes.driveLine = (state == ST_TX);
  end

endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import sspPkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  sspStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;

  // one register serves both directions, always shifting toward bit 0
  always_comb begin
    shiftNext = shiftReg;
    if (strobes.loadTx)        shiftNext = wrData;
    else if (strobes.clearRx)  shiftNext = '0;
    else if (strobes.sampleRx) shiftNext = {sdIn, shiftReg[DATA_W-1:1]};
    else if (strobes.shiftTx)  shiftNext = {1'b0, shiftReg[DATA_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      rxData   <= '0;
    end else begin
      shiftReg <= shiftNext;
      if (strobes.commitRx) rxData <= shiftNext;
    end
  end

  assign sdOe  = strobes.driveLine;
  assign sdOut = strobes.driveLine ? shiftReg[0] : IDLE_LEVEL;

endmodule

// File: rtl/ssp_sync_port.sv
module ssp_sync_port
  import sspPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4,
  parameter int SLOW_LOW = 10,
  parameter int FAST_LOW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxEnable,
  input  logic              fastMode,
  input  logic              txDoneClr,
  input  logic              rxDoneClr,
  input  logic              sdIn,
  output logic              sdOut,
  output logic              sdOe,
  output logic              shiftClk,
  output logic [DATA_W-1:0] rxData,
  output logic              txDone,
  output logic              rxDone,
  output logic              busy
);

  sspStrobes_t strobes;

  ssp_ctrl #(
    .DATA_W(DATA_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV),
    .SLOW_LOW(SLOW_LOW), .FAST_LOW(FAST_LOW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rxEnable(rxEnable),
    .fastMode(fastMode), .txDoneClr(txDoneClr), .rxDoneClr(rxDoneClr),
    .strobes(strobes), .shiftClk(shiftClk), .busy(busy),
    .txDone(txDone), .rxDone(rxDone)
  );

  ssp_datapath #(.DATA_W(DATA_W), .IDLE_LEVEL(1'b1)) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe), .rxData(rxData)
  );

endmodule

// File: rtl/ssp_sync_port_chk.sv
module ssp_sync_port_chk #(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic fastMode,
  input logic txDoneClr,
  input logic rxDoneClr,
  input logic sdOut,
  input logic sdOe,
  input logic shiftClk,
  input logic txDone,
  input logic rxDone,
  input logic busy
);

  int   busyCnt;
  logic modeQ;

  always_ff @(posedge clk) begin
    if (rst || !busy) busyCnt <= 0;
    else              busyCnt <= busyCnt + 1;
    if (rst)          modeQ <= 1'b0;
    else if (!busy)   modeQ <= fastMode;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !sdOe && !txDone && !rxDone && shiftClk)); // R9

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> shiftClk); // R2

  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    sdOe |-> busy); // R3

  AST_TX_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    (sdOe && $rose(shiftClk)) |-> $stable(sdOut)); // R3

  AST_XFER_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |->
      (busyCnt == (modeQ ? FAST_DIV * DATA_W : SLOW_DIV * DATA_W))); // R1

  AST_TXDONE_HELD: assert property (@(posedge clk) disable iff (rst)
    (txDone && !txDoneClr) |=> txDone); // R6

  AST_RXDONE_HELD: assert property (@(posedge clk) disable iff (rst)
    (rxDone && !rxDoneClr) |=> rxDone); // R6

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($rose(txDone) || $rose(rxDone)) |-> !busy); // R6

  AST_NO_TX_DURING_RX: assert property (@(posedge clk) disable iff (rst)
    (busy && !sdOe) |=> !sdOe); // R7

endmodule

bind ssp_sync_port ssp_sync_port_chk #(
  .DATA_W(DATA_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)
) u_chk (.*);

// File: tb/tb_ssp_sync_port.sv
`timescale 1ns/1ps
module tb_ssp_sync_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rxEnable = 1'b0;
  logic       fastMode = 1'b0;
  logic       txDoneClr = 1'b0;
  logic       rxDoneClr = 1'b0;
  logic       sdIn = 1'b1;
  logic       sdOut, sdOe, shiftClk, txDone, rxDone, busy;
  logic [7:0] rxData;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk; // 50 MHz

  ssp_sync_port dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rxEnable(rxEnable),
    .fastMode(fastMode), .txDoneClr(txDoneClr), .rxDoneClr(rxDoneClr),
    .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe), .shiftClk(shiftClk),
    .rxData(rxData), .txDone(txDone), .rxDone(rxDone), .busy(busy)
  );

  // {fast, receive, byte}
  localparam logic [9:0] VECS [6] = '{
    {1'b0, 1'b0, 8'hA5},
    {1'b1, 1'b0, 8'h3C},
    {1'b0, 1'b1, 8'h96},
    {1'b1, 1'b1, 8'h01},
    {1'b1, 1'b0, 8'h80},
    {1'b0, 1'b1, 8'hE7}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one full transfer; 'intrude' fires extra start requests mid-transfer,
  // 'keepFlag' leaves the completion flag set afterwards
  task automatic runXfer(input logic fast, input logic rx, input logic [7:0] d,
                         input logic intrude, input logic keepFlag);
    int per = fast ? 4 : 12;
    int rise = fast ? 3 : 10;
    int errClk = 0, errLine = 0, errBusy = 0;
    fastMode = fast;
    if (rx) rxEnable = 1'b1;
    else begin wrEn = 1'b1; wrData = d; end
    tick();
    wrEn = 1'b0;
    rxEnable = 1'b0;
    fastMode = ~fast; // must not alter the running transfer (R1)
    for (int k = 0; k < 8 * per; k++) begin
      int ph = k % per;
      int b = k / per;
      if (rx) sdIn = (ph == rise) ? d[b] : ~d[b];
      if (intrude && k == 5) begin wrEn = 1'b1; wrData = ~d; rxEnable = 1'b1; end
      if (intrude && k == 6) begin wrEn = 1'b0; rxEnable = 1'b0; end
      if (shiftClk !== (ph >= rise)) errClk++;
      if (busy !== 1'b1) errBusy++;
      if (rx) begin
        if (sdOe !== 1'b0) errLine++;
      end else if (sdOe !== 1'b1 || sdOut !== d[b]) errLine++;
      tick();
    end
    chk("R2", "shift clock pattern errors", errClk, 0);
    chk("R1", "busy gaps during transfer", errBusy, 0);
    chk(rx ? "R4" : (intrude ? "R7" : "R3"), "line drive errors", errLine, 0);
    chk("R1", "busy low after 8 bits", busy, 1'b0);
    chk("R6", "completion flag", rx ? rxDone : txDone, 1'b1);
    if (rx) chk("R5", "received byte", rxData, d);
    if (!keepFlag) begin
      if (rx) rxDoneClr = 1'b1; else txDoneClr = 1'b1;
      tick();
      rxDoneClr = 1'b0;
      txDoneClr = 1'b0;
      chk("R6", "flag after clear", rx ? rxDone : txDone, 1'b0);
    end
  endtask

  initial begin
    tick();
    tick();
    rst = 1'b0;
    // R9: reset state
    chk("R9", "busy after reset", busy, 1'b0);
    chk("R9", "shiftClk after reset", shiftClk, 1'b1);
    chk("R9", "sdOe after reset", sdOe, 1'b0);
    chk("R9", "flags after reset", {txDone, rxDone}, 2'b00);

    foreach (VECS[v]) runXfer(VECS[v][9], VECS[v][8], VECS[v][7:0], 1'b0, 1'b0);

    // R7: start requests during a transmit are ignored
    runXfer(1'b1, 1'b0, 8'h5A, 1'b1, 1'b0);

    // R6 and R7: flag held without a clear; receive refused while it is set
    runXfer(1'b1, 1'b1, 8'hC3, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) tick();
    chk("R6", "rxDone held without clear", rxDone, 1'b1);
    rxEnable = 1'b1;
    tick();
    tick();
    chk("R7", "no receive while rxDone set", busy, 1'b0);
    chk("R7", "clock idle while refused", shiftClk, 1'b1);
    rxEnable = 1'b0;
    rxDoneClr = 1'b1;
    tick();
    rxDoneClr = 1'b0;

    // R8: simultaneous requests start a transmit
    fastMode = 1'b1;
    wrData = 8'h01;
    wrEn = 1'b1;
    rxEnable = 1'b1;
    tick();
    wrEn = 1'b0;
    rxEnable = 1'b0;
    chk("R8", "transmit wins", sdOe, 1'b1);
    for (int i = 0; i < 40 && busy; i++) tick();
    chk("R8", "transmit flag after tie", {txDone, rxDone}, 2'b10);

    // R9: reset in the middle of a transfer
    fastMode = 1'b0;
    wrData = 8'hFF;
    wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
    for (int i = 0; i < 20; i++) tick();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    chk("R9", "idle after mid reset", {busy, sdOe, shiftClk}, 3'b001);
    chk("R9", "flags cleared by reset", {txDone, rxDone}, 2'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule